// File: doc/BRIEF.md
# Input-Change Interrupt with Port Capture

This block watches a 16-bit general-purpose input port and tells the host when any input has moved away from the value the host last saw. Each pin first passes through a digital glitch filter that only accepts a new level once it has held for several internal clocks. The filtered port is compared, bit by bit, against a stored reference that is refreshed whenever the host reads the port or the capture register. Only bits marked as inputs by the direction mask take part in the compare.

When a difference is found, the block raises an active-low open-drain interrupt and freezes a snapshot of the whole filtered port in a read-only capture register, presented as a low byte and a high byte. The snapshot stays put while the interrupt is pending. Any of the four host read strobes (port low, port high, capture low, capture high) clears the interrupt and reloads the reference from the current filtered inputs. The block drives only the enable of the interrupt pad driver: when the enable is high, the pad pulls the line low.

Top module: `inchg_irq_capture`

## Requirements
- R1: After a synchronous active-low reset, `irq_pull_o` is 0 and the capture outputs read 0000h (low byte 00h, high byte 00h).
- R2: A pin level is accepted by the filter only after it has been sampled at the new level on 4 consecutive clock edges; a pulse that lasts 3 clocks or fewer causes no interrupt, while a pulse of exactly 4 clocks is accepted.
- R3: `irq_pull_o` becomes 1 when any filtered input bit differs from the stored reference; for a pin change applied before clock edge 1, it is 0 after edge 4 and 1 after edge 5.
- R4: In the cycle the interrupt is raised, the capture register takes the whole filtered port; `cap_lo_o` shows bits 7:0 and `cap_hi_o` shows bits 15:8.
- R5: While the interrupt is pending, further input changes do not alter the capture register.
- R6: A one-cycle pulse on any of `rd_port_lo_i`, `rd_port_hi_i`, `rd_cap_lo_i`, `rd_cap_hi_i` clears `irq_pull_o` after that edge and reloads the reference from the filtered inputs, so an input that stays at its new level does not raise the interrupt again; the read does not change the capture register.
- R7: Bits whose `dir_in_i` bit is 0 (output) never raise the interrupt; a bit with `dir_in_i` = 1 is an input.
- R8: A read strobe on the same edge as a detected change takes precedence: no interrupt is raised and the capture register keeps its old value.
- R9: A pending interrupt stays asserted even if the inputs return to the reference value before the host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pins_i | input | 16 | Port pin levels, already synchronized to clk |
| dir_in_i | input | 16 | Direction mask, 1 = bit is an input and takes part in the compare |
| rd_port_lo_i | input | 1 | One-cycle strobe: host reads port bits 7:0 |
| rd_port_hi_i | input | 1 | One-cycle strobe: host reads port bits 15:8 |
| rd_cap_lo_i | input | 1 | One-cycle strobe: host reads capture bits 7:0 |
| rd_cap_hi_i | input | 1 | One-cycle strobe: host reads capture bits 15:8 |
| cap_lo_o | output | 8 | Captured port bits 7:0 |
| cap_hi_o | output | 8 | Captured port bits 15:8 |
| irq_pull_o | output | 1 | Interrupt pad enable, 1 = pull the open-drain line low |

## Verification
A wrong filter count shows as the interrupt arriving one edge early or late after a pin change, or as a three-clock glitch raising it; the bench pins the exact edge on which `irq_pull_o` first rises. A stale or unreloaded reference shows as the interrupt firing again within five edges after a read while the pins hold still, and a capture register that is not frozen shows as the capture bytes following a second change within five edges. A wrong masking or read priority shows on the first edge on which the affected change would have been accepted.

// File: rtl/inchg_pkg.sv
// Package: shared defaults for the input-change interrupt block.
// Assumes: the port is built from two equal halves.
package inchg_pkg;
    localparam int unsigned DEF_HALF_W = 8;
    localparam int unsigned DEF_STABLE = 4;

    // Width of a counter that must reach the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/inchg_filter_bit.sv
// Module: one-bit glitch filter.
// Accepts a new level only after it has been sampled on STABLE consecutive
// edges. Assumes pin_i is already synchronized to clk. Reset level is 0.
module inchg_filter_bit #(
    parameter int unsigned STABLE = inchg_pkg::DEF_STABLE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic filt_o
);
    localparam int unsigned CW = inchg_pkg::cnt_width(STABLE);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    logic          filt_q;
    logic [CW-1:0] cnt_q;

    // Count edges at the new level; adopt it on the STABLE-th one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pin_i != filt_q) begin
            if (cnt_q == LAST) begin
                filt_q <= pin_i;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign filt_o = filt_q;

    // R2: the filtered level only moves to the level just sampled on the pin
    a_r2_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> (filt_q == $past(pin_i)));

    // R2: the filtered level only moves after a full run of stable samples
    a_r2_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/inchg_filter.sv
// Module: glitch filter for a whole port, one filter per bit.
// Assumes all bits share one clock and reset.
module inchg_filter #(
    parameter int unsigned WIDTH  = 2 * inchg_pkg::DEF_HALF_W,
    parameter int unsigned STABLE = inchg_pkg::DEF_STABLE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] filt_o
);
    // One independent filter per port bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        inchg_filter_bit #(.STABLE(STABLE)) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins_i[b]),
            .filt_o (filt_o[b])
        );
    end
endmodule

// File: rtl/inchg_detect.sv
// Module: change detector with host-refreshed reference.
// Compares the filtered port with the reference on input-direction bits,
// holds a pending flag until any read, and reloads the reference on a read.
// A read on the same edge as a detection wins. fire_o pulses for one
// cycle in the cycle the pending flag is about to be set.
module inchg_detect #(
    parameter int unsigned WIDTH = 2 * inchg_pkg::DEF_HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] filt_i,
    input  logic [WIDTH-1:0] dir_in_i,
    input  logic             rd_any_i,
    output logic             fire_o,
    output logic             pend_o
);
    logic [WIDTH-1:0] ref_q;
    logic             pend_q;
    logic             differs;

    // Any input-direction bit away from the reference.
    always_comb differs = |((filt_i ^ ref_q) & dir_in_i);

    // New detection: only when idle and no read on this edge.
    always_comb fire_o = differs && !pend_q && !rd_any_i;

    // Reference reload on read, pending flag set on detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            pend_q <= 1'b0;
        end else if (rd_any_i) begin
            ref_q  <= filt_i;
            pend_q <= 1'b0;
        end else if (fire_o) begin
            pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

    // R6: any read leaves the interrupt deasserted
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any_i |=> !pend_q);

    // R9: without a read, a pending interrupt stays pending
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !rd_any_i) |=> pend_q);

    // R7: a rise needs an input-direction bit away from the reference
    a_r7_masked_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(|((filt_i ^ ref_q) & dir_in_i)));

    // R8: no rise on an edge that carried a read
    a_r8_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> !$past(rd_any_i));
endmodule

// File: rtl/inchg_capture.sv
// Module: port snapshot register.
// Loads the filtered port when the detector fires, otherwise holds.
module inchg_capture #(
    parameter int unsigned WIDTH = 2 * inchg_pkg::DEF_HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [WIDTH-1:0] filt_i,
    output logic [WIDTH-1:0] cap_o
);
    logic [WIDTH-1:0] cap_q;

    // Take the snapshot on a detection only.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (fire_i) cap_q <= filt_i;
    end

    assign cap_o = cap_q;
endmodule

// File: rtl/inchg_irq_capture.sv
// Module: input-change interrupt with port capture (top).
// Filters the pins, detects a change against the host-refreshed reference,
// snapshots the port and drives the open-drain interrupt enable.
// Assumes pins are synchronized and read strobes last one cycle.
module inchg_irq_capture #(
    parameter int unsigned HALF_W = inchg_pkg::DEF_HALF_W,
    parameter int unsigned STABLE = inchg_pkg::DEF_STABLE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*HALF_W-1:0] pins_i,
    input  logic [2*HALF_W-1:0] dir_in_i,
    input  logic                rd_port_lo_i,
    input  logic                rd_port_hi_i,
    input  logic                rd_cap_lo_i,
    input  logic                rd_cap_hi_i,
    output logic [HALF_W-1:0]   cap_lo_o,
    output logic [HALF_W-1:0]   cap_hi_o,
    output logic                irq_pull_o
);
    localparam int unsigned WIDTH = 2 * HALF_W;

    logic [WIDTH-1:0] filt;
    logic [WIDTH-1:0] cap;
    logic             rd_any;
    logic             fire;
    logic             pend;

    // Any of the four host reads counts as acknowledging the change.
    always_comb rd_any = rd_port_lo_i | rd_port_hi_i | rd_cap_lo_i | rd_cap_hi_i;

    inchg_filter #(.WIDTH(WIDTH), .STABLE(STABLE)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .filt_o (filt)
    );

    inchg_detect #(.WIDTH(WIDTH)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_i   (filt),
        .dir_in_i (dir_in_i),
        .rd_any_i (rd_any),
        .fire_o   (fire),
        .pend_o   (pend)
    );

    inchg_capture #(.WIDTH(WIDTH)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .filt_i (filt),
        .cap_o  (cap)
    );

    assign cap_lo_o   = cap[HALF_W-1:0];
    assign cap_hi_o   = cap[WIDTH-1:HALF_W];
    assign irq_pull_o = pend;

    // R4: the snapshot equals the filtered port of the detecting cycle
    a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_o) |-> ({cap_hi_o, cap_lo_o} == $past(filt)));

    // R5: the capture only moves when the interrupt rises
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cap_hi_o, cap_lo_o}) |-> $rose(irq_pull_o));

    // R1: while reset is held, outputs sit at their idle values next edge
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!irq_pull_o && cap_lo_o == '0 && cap_hi_o == '0));
endmodule

// File: tb/tb_inchg_irq_capture.sv
// Bench: scoreboard. The driver pushes the expected outputs for the state
// after the next rising edge; the monitor pops and compares after that edge.
module tb_inchg_irq_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic [15:0] dir_in = 16'hFFFF;
    logic        rd_plo = 1'b0, rd_phi = 1'b0, rd_clo = 1'b0, rd_chi = 1'b0;
    logic [7:0]  cap_lo, cap_hi;
    logic        irq_pull;

    typedef struct {
        string       tag;
        logic        irq;
        logic [15:0] cap;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   drv_done = 1'b0;

    always #4 clk = ~clk;

    inchg_irq_capture dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .dir_in_i     (dir_in),
        .rd_port_lo_i (rd_plo),
        .rd_port_hi_i (rd_phi),
        .rd_cap_lo_i  (rd_clo),
        .rd_cap_hi_i  (rd_chi),
        .cap_lo_o     (cap_lo),
        .cap_hi_o     (cap_hi),
        .irq_pull_o   (irq_pull)
    );

    // Expect these outputs after the next rising edge.
    task automatic exp_next(input string tag, input logic irq, input logic [15:0] cap);
        exp_t e;
        e.tag = tag; e.irq = irq; e.cap = cap;
        q.push_back(e);
    endtask

    // Hold the inputs for n cycles, expecting the same outputs after each edge.
    task automatic run(input int n, input logic irq, input logic [15:0] cap, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_next(tag, irq, cap);
            @(negedge clk);
        end
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (irq_pull !== e.irq || {cap_hi, cap_lo} !== e.cap) begin
                    n_bad++;
                    $display("FAIL %s: irq=%b cap=%h, expected irq=%b cap=%h",
                             e.tag, irq_pull, {cap_hi, cap_lo}, e.irq, e.cap);
                end
            end
        end
    end

    // Driver.
    initial begin
        @(negedge clk);
        run(3, 1'b0, 16'h0000, "R1 reset held");
        rst_n = 1'b1;
        run(2, 1'b0, 16'h0000, "R1 after reset");

        // R2: a three-clock glitch is rejected
        pins = 16'h0001;
        run(3, 1'b0, 16'h0000, "R2 glitch");
        pins = 16'h0000;
        run(6, 1'b0, 16'h0000, "R2 glitch rejected");

        // R3/R4: latency and snapshot
        pins = 16'h1234;
        run(4, 1'b0, 16'h0000, "R3 filter latency");
        run(1, 1'b1, 16'h1234, "R3 R4 raise and capture");

        // R5: further change while pending
        pins = 16'hABCD;
        run(8, 1'b1, 16'h1234, "R5 capture frozen");
        // R9: inputs back at the reference
        pins = 16'h0000;
        run(8, 1'b1, 16'h1234, "R9 pending held");

        // R6: capture-low read clears
        rd_clo = 1'b1;
        exp_next("R6 read clears", 1'b0, 16'h1234);
        @(negedge clk);
        rd_clo = 1'b0;
        run(10, 1'b0, 16'h1234, "R6 no refire");

        pins = 16'h00F0;
        run(4, 1'b0, 16'h1234, "R3 second change latency");
        run(1, 1'b1, 16'h00F0, "R3 R4 second capture");
        rd_phi = 1'b1;
        exp_next("R6 port-high read clears", 1'b0, 16'h00F0);
        @(negedge clk);
        rd_phi = 1'b0;
        run(8, 1'b0, 16'h00F0, "R6 reference reloaded");

        // R7: output-direction bits ignored
        dir_in = 16'h00FF;
        pins = 16'hF0F0;
        run(10, 1'b0, 16'h00F0, "R7 masked change");
        pins = 16'hF0F1;
        run(4, 1'b0, 16'h00F0, "R7 input bit latency");
        run(1, 1'b1, 16'hF0F1, "R7 R4 input bit raises");
        rd_plo = 1'b1;
        exp_next("R6 port-low read clears", 1'b0, 16'hF0F1);
        @(negedge clk);
        rd_plo = 1'b0;
        run(3, 1'b0, 16'hF0F1, "R6 idle");

        // R8: read on the detecting edge wins
        pins = 16'hF0F3;
        run(4, 1'b0, 16'hF0F1, "R8 latency");
        rd_chi = 1'b1;
        exp_next("R8 read wins", 1'b0, 16'hF0F1);
        @(negedge clk);
        rd_chi = 1'b0;
        run(6, 1'b0, 16'hF0F1, "R8 no raise");

        // R2: exactly four clocks is accepted
        pins = 16'hF0F7;
        run(4, 1'b0, 16'hF0F1, "R2 four-clock pulse");
        pins = 16'hF0F3;
        run(1, 1'b1, 16'hF0F7, "R2 four-clock pulse accepted");
        run(6, 1'b1, 16'hF0F7, "R5 R9 held after pulse");

        // R1: reset in mid-operation
        rst_n = 1'b0;
        run(2, 1'b0, 16'h0000, "R1 reset clears");
        rst_n = 1'b1;
        @(negedge clk);
        drv_done = 1'b1;
    end

    // Finish when the driver is done and the scoreboard is empty; watchdog.
    initial begin
        int cyc = 0;
        while (!(drv_done && q.size() == 0) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        #3;
        if (cyc >= 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<20000", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule